// File: doc/BRIEF.md
# Read-Path Successive-Approximation Accelerator

This block sits between a processor's I/O bus and a small DAC code register. It speeds up a successive-approximation conversion by changing the data returned when the processor reads that register. Each conversion step is an ordinary read-modify-write. The processor reads the register and then writes the same value straight back. During the read, the block replaces two bits of the returned value. The earlier trial bit is set or cleared from the latched comparator decision, and the next lower bit is raised as the new trial. The DAC sees the new code only once the processor writes that value back.

An internal step counter chooses which two bits are replaced. The counter starts again whenever the block is armed. One pass resolves `NBITS` bits in `NBITS+1` accelerated reads. After the last read the block reports completion and stops altering data until it is armed again. A wider result is built by running several passes. The bus strobes are single-cycle and always accepted: there is no valid/ready handshake and no back-pressure on either data bus. A read is answered in the cycle its strobe is high, and a write takes effect at the end of its cycle.

Top module: `sar_read_assist`

## Requirements
- R1: After reset the DAC code (`dac_code`) is 0, `busy` and `done` are 0, and `rd_data` is 0.
- R2: A cycle with `wr_stb` and `sel` high loads `wr_data` into the register. `dac_code` shows the low `NBITS` bits from the next cycle. While the block is not busy, a selected read returns the register unchanged.
- R3: On an accelerated read, `rd_data` differs from the register only at the correction position and the guess position. The bits above the `NBITS`-bit field always pass through.
- R4: The first accelerated read after `arm` sets bit `NBITS-1` (bit 5) to 1 and corrects nothing.
- R5: Accelerated read number k+1, for k from 1 to `NBITS-1`, makes two changes. It sets bit `NBITS-k` to the effective comparator value, and it sets bit `NBITS-1-k` to 1.
- R6: Accelerated read number `NBITS+1` sets bit 0 to the effective comparator value and changes no other bit. In the next cycle `done` is 1 and `busy` is 0. After that, selected reads return the register unchanged until the next `arm`.
- R7: The effective comparator value is the latched comparator bit XOR `cmp_invert`. A value of 1 keeps the trial bit at 1, and a value of 0 clears it.
- R8: The step counter advances only on a read with `sel` high while busy. Writes, and reads with `sel` low, leave it unchanged. A read with `sel` low returns 0.
- R9: The comparator is captured on every clock edge at which `rd_stb` is low, and it is held while `rd_stb` is high. A read therefore uses the value `cmp_in` had in the cycle before the strobe, and a change of `cmp_in` during the read has no effect.
- R10: `arm` at any time, including after `done`, clears `done`, sets `busy`, and restarts the sequence at R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new pass (one-cycle pulse) |
| cmp_invert | input | 1 | Invert the comparator sense |
| cmp_in | input | 1 | Raw comparator output |
| rd_stb | input | 1 | I/O read strobe, one cycle per access |
| wr_stb | input | 1 | I/O write strobe, one cycle per access |
| sel | input | 1 | Address matches the DAC register |
| wr_data | input | DW | Write data bus |
| rd_data | output | DW | Read data bus, valid while `rd_stb` and `sel` are high |
| dac_code | output | NBITS | Code applied to the DAC |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass complete |

## Verification
`rd_data` is combinational. It is due in the same cycle as its read strobe and is sampled 1 ns after the falling edge that raised the strobe. The comparator that read uses is driven one full cycle earlier. A written value appears on `dac_code` one rising edge later. `done` and `busy` change at the edge that ends the final read, so both are sampled at the following falling edge. The bench closes the loop for all 64 input levels under both comparator polarities, and it checks every returned word against the expected two-bit pattern. It checks the final code against the input level. Directed steps cover reads with `sel` low, writes during a pass, comparator changes during a read, pass-through after completion, and re-arming.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_step_ctr.sv
module sar_step_ctr
  import sar_pkg::*;
#(
  parameter int NBITS = 6,
  localparam int SW = $clog2(NBITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          adv,
  output logic [SW-1:0] step,
  output phase_t        phase
);
  localparam logic [SW-1:0] LAST = SW'(NBITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step  <= '0;
      phase <= PH_IDLE;
    end else if (arm) begin
      step  <= '0;
      phase <= PH_RUN;
    end else if (adv && phase == PH_RUN) begin
      if (step == LAST) begin
        step  <= '0;
        phase <= PH_DONE;
      end else begin
        step <= step + SW'(1);
      end
    end
  end

  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !arm && phase == PH_RUN && step != LAST) |=> step == $past(step) + SW'(1));
  a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !arm && phase == PH_RUN && step == LAST) |=> phase == PH_DONE);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !arm) |=> $stable(step) && $stable(phase));
  a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> phase == PH_RUN && step == '0);
endmodule

// File: rtl/sar_bit_mask.sv
module sar_bit_mask #(
  parameter int DW    = 8,
  parameter int NBITS = 6,
  localparam int SW = $clog2(NBITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic [SW-1:0] step,
  output logic [DW-1:0] corr_mask,
  output logic [DW-1:0] guess_mask
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i < NBITS) begin : g_fld
      assign corr_mask[i]  = running && (step == SW'(NBITS - i));
      assign guess_mask[i] = running && (step == SW'(NBITS - 1 - i));
    end else begin : g_hi
      assign corr_mask[i]  = 1'b0;
      assign guess_mask[i] = 1'b0;
    end
  end

  a_r3_one_each: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(corr_mask) && $onehot0(guess_mask) && ((corr_mask & guess_mask) == '0));
  a_r3_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_mask != '0 && guess_mask != '0) |-> (corr_mask == (guess_mask << 1)));
endmodule

// File: rtl/sar_overlay.sv
module sar_overlay #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] reg_in,
  input  logic [DW-1:0] corr_mask,
  input  logic [DW-1:0] guess_mask,
  input  logic          decision,
  output logic [DW-1:0] data_out
);
  for (genvar i = 0; i < DW; i++) begin : g_ov
    assign data_out[i] = guess_mask[i] ? 1'b1 :
                         corr_mask[i]  ? decision : reg_in[i];
  end
endmodule

// File: rtl/sar_read_assist.sv
module sar_read_assist
  import sar_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NBITS = 6,
  localparam int SW = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             cmp_invert,
  input  logic             cmp_in,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic             sel,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic [NBITS-1:0] dac_code,
  output logic             busy,
  output logic             done
);
  logic [DW-1:0] dac_q;
  logic          cmp_hold;
  logic [SW-1:0] step;
  phase_t        phase;
  logic [DW-1:0] corr_mask, guess_mask, ov_data;
  logic          rd_hit;

  assign rd_hit = rd_stb && sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       cmp_hold <= 1'b0;
    else if (!rd_stb) cmp_hold <= cmp_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              dac_q <= '0;
    else if (wr_stb && sel)  dac_q <= wr_data;
  end

  sar_step_ctr #(.NBITS(NBITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .arm(arm), .adv(rd_hit),
    .step(step), .phase(phase)
  );

  sar_bit_mask #(.DW(DW), .NBITS(NBITS)) u_mask (
    .clk(clk), .rst_n(rst_n), .running(phase == PH_RUN), .step(step),
    .corr_mask(corr_mask), .guess_mask(guess_mask)
  );

  sar_overlay #(.DW(DW)) u_ov (
    .reg_in(dac_q), .corr_mask(corr_mask), .guess_mask(guess_mask),
    .decision(cmp_hold ^ cmp_invert), .data_out(ov_data)
  );

  assign rd_data  = rd_hit ? ov_data : '0;
  assign dac_code = dac_q[NBITS-1:0];
  assign busy     = (phase == PH_RUN);
  assign done     = (phase == PH_DONE);

  a_r9_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stb) |-> $stable(cmp_hold));
  a_r3_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> ((rd_data ^ dac_q) & ~{{(DW-NBITS){1'b0}}, {NBITS{1'b1}}}) == '0);
  a_r3_two_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> $countones((rd_data ^ dac_q) & ~(corr_mask | guess_mask)) == 0);
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !busy) |-> rd_data == dac_q);
  a_r6_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r8_unsel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> rd_data == '0);
endmodule

// File: tb/sar_read_assist_test.sv
`timescale 1ns/1ps
module sar_read_assist_test;
  localparam int DW = 8;
  localparam int NB = 6;

  logic clk = 0;
  logic rst_n = 0, arm = 0, cmp_invert = 0, cmp_in = 0;
  logic rd_stb = 0, wr_stb = 0, sel = 0;
  logic [DW-1:0] wr_data = 0;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] dac_code;
  logic busy, done;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] shadow;

  always #2 clk = ~clk;

  sar_read_assist #(.DW(DW), .NBITS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cmp_invert(cmp_invert), .cmp_in(cmp_in),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .sel(sel), .wr_data(wr_data),
    .rd_data(rd_data), .dac_code(dac_code), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [DW-1:0] v);
    @(negedge clk); rd_stb = 0; sel = 1; wr_stb = 1; wr_data = v;
    @(negedge clk); wr_stb = 0; sel = 0;
    shadow = v;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  // one accelerated step; s = index of read since arm
  task automatic rmw_step(input int s, input bit inv, input int vin, input string req);
    logic [DW-1:0] exp, got;
    bit eff;
    @(negedge clk); wr_stb = 0; sel = 0;
    eff = (vin >= int'(dac_code));
    cmp_in = eff ^ inv; cmp_invert = inv;
    @(negedge clk); rd_stb = 1; sel = 1;
    #1;
    got = rd_data;
    exp = shadow;
    if (s > 0)  exp[NB - s] = eff;
    if (s < NB) exp[NB - 1 - s] = 1'b1;
    chk(got == exp, req, got, exp);
    @(negedge clk); rd_stb = 0; wr_stb = 1; wr_data = got;
    shadow = got;
  endtask

  task automatic plain_read(input logic [DW-1:0] exp, input string req);
    @(negedge clk); wr_stb = 0; rd_stb = 1; sel = 1;
    #1 chk(rd_data == exp, req, rd_data, exp);
    @(negedge clk); rd_stb = 0; sel = 0;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dac_code == 0, "R1 dac_code", dac_code, 0);
    chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);

    bus_write(8'hA5);
    chk(dac_code == 6'h25, "R2 write", dac_code, 6'h25);
    plain_read(8'hA5, "R2 idle read");

    // full sweep: both polarities, all levels, upper bits preserved
    for (int inv = 0; inv < 2; inv++) begin
      for (int v = 0; v < 64; v++) begin
        bus_write(8'h80);
        do_arm();
        chk(busy == 1 && done == 0, "R10 armed", {busy, done}, 2);
        for (int s = 0; s <= NB; s++)
          rmw_step(s, inv[0], v, s == 0 ? "R4" : (s == NB ? "R6" : (inv ? "R7" : "R5")));
        @(negedge clk); wr_stb = 0; sel = 0;
        chk(dac_code == v[5:0], "R5 result", dac_code, v);
        chk(rd_data == 0 && done == 1 && busy == 0, "R6 done", {busy, done}, 1);
        chk(uut.rd_data == 0, "R8 unselected idle", rd_data, 0);
      end
    end
    plain_read({2'b10, 6'd63}, "R6 passthrough after done");
    chk(done == 1, "R6 done held", done, 1);

    // R8: unselected reads and writes do not advance
    cmp_invert = 0;
    bus_write(8'h00);
    do_arm();
    @(negedge clk); rd_stb = 1; sel = 0;
    #1 chk(rd_data == 0, "R8 unselected read", rd_data, 0);
    @(negedge clk); rd_stb = 0;
    bus_write(8'h00);
    rmw_step(0, 0, 40, "R8 still first step");
    rmw_step(1, 0, 40, "R5 second step");

    // R9: change comparator during read
    @(negedge clk); wr_stb = 0; sel = 0; cmp_in = 1;
    @(negedge clk); rd_stb = 1; sel = 1; cmp_in = 0;
    #1 chk(rd_data[4] == 1'b1 && rd_data[3] == 1'b1, "R9 latched cmp", rd_data, shadow | 8'h18);
    @(negedge clk); rd_stb = 0; sel = 0;

    // R10: re-arm mid pass restarts
    bus_write(8'h00);
    do_arm();
    rmw_step(0, 0, 10, "R10 restart");
    chk(busy == 1, "R10 busy", busy, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule